// File: doc/BRIEF.md
# MSI interrupt message generator

This block converts an interrupt request from user logic into one PCI Express Memory Write request that carries a Message Signaled Interrupt. The requester raises one bit of a one-hot request vector for each vector it wants to signal. The block remembers every accepted request as pending. It services the pending vectors one at a time and streams each message as a sequence of 32-bit dwords over a valid/ready handshake. After the last dword has been accepted, it pulses an acknowledgement together with the number of the vector that was sent.

System software programs the capability values: the enable, the message address, the upper address, the 16-bit message data and a 3-bit multiple-message-enable code. These values arrive as plain inputs. A parameter sets how many vectors the function supports, given as a log2 value. The number of low data bits that carry the vector number is the smaller of the parameter and the enable code. Request bits beyond that vector count are discarded. The block does not check per-vector mask bits, so the requester must consult them before it raises a request.

Top module: `msi_msg_gen`

## Requirements
- R1: When the upper address input is zero, a message is 4 beats: 0x40000001 (format 010, type 00000, length 1), then 0x0000000F (requester ID and tag zero, last byte enable 0000, first byte enable 1111), then the message address with bits [1:0] forced to 0, then the payload.
- R2: When the upper address input is non-zero, a message is 5 beats: 0x60000001 (format 011, type 00000, length 1), then 0x0000000F, then the upper address, then the message address with bits [1:0] forced to 0, then the payload.
- R3: The payload dword is the 16-bit message data zero-extended to 32 bits, with its low n bits replaced by the vector number. n is the smaller of the enable code and the capability parameter (5 by default), so codes 6 and 7 act as the capability value.
- R4: A request bit whose index is 2^n or higher has no effect. With n equal to 0, only bit 0 produces a message.
- R5: When several vectors are pending, the lowest-numbered vector is sent first. Every pending vector then produces its own message in turn.
- R6: While the enable is low, requests are dropped and vectors already pending are discarded. No message is started and no acknowledgement is given for them. A message that is already being sent completes.
- R7: A beat is taken only in a cycle in which valid and ready are both high. While valid is high and ready is low, the data and last outputs hold. Last is high only on the final beat.
- R8: The sent output is high for exactly one cycle, the cycle after the final beat is accepted, and the sent-vector output then gives the vector number of that message.
- R9: A request that arrives in the same cycle that its own vector is taken for sending is kept, so a second message for that vector follows.
- R10: After reset, valid and sent are low. When the block is idle, a request sampled on one rising edge makes valid high after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en | input | 1 | MSI enable from the capability |
| msi_mme | input | 3 | Multiple-message-enable code (2^code vectors) |
| msi_addr_lo | input | 32 | Message address, lower 32 bits |
| msi_addr_hi | input | 32 | Message upper address; non-zero selects 64-bit addressing |
| msi_data | input | 16 | Message data |
| irq_req | input | 32 | One-hot interrupt request, bit N for vector N |
| tlp_valid | output | 1 | Output dword valid |
| tlp_ready | input | 1 | Downstream accepts the dword |
| tlp_data | output | 32 | Output dword |
| tlp_last | output | 1 | Final dword of the message |
| msi_sent | output | 1 | One-cycle pulse after a message has gone out |
| msi_sent_vec | output | 5 | Vector number of the message just sent |

## Verification
In the same cycle, the pending bit of a vector can be cleared because that vector is taken for sending and set again by a fresh request for it. The bench provokes this by holding one request bit high for two consecutive cycles from idle, so the second sample lands on the grant edge. It judges the result by two observations: valid must rise right after that grant edge, and exactly two complete messages with two acknowledgements must follow for the same vector.

// File: rtl/msi_pkg.sv
package msi_pkg;

  localparam int DW_W = 32;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } beat_st_e;

  localparam logic [2:0] FMT_3DW_WITH_DATA = 3'b010;
  localparam logic [2:0] FMT_4DW_WITH_DATA = 3'b011;
  localparam logic [4:0] TYPE_MEM          = 5'b00000;
  localparam logic [9:0] LEN_ONE_DW        = 10'd1;
  localparam logic [3:0] BE_FIRST_ALL      = 4'hF;
  localparam logic [3:0] BE_LAST_NONE      = 4'h0;

  // beat positions inside one message
  localparam logic [2:0] BEAT_DW0  = 3'd0;
  localparam logic [2:0] BEAT_DW1  = 3'd1;
  localparam logic [2:0] BEAT_DW2  = 3'd2;
  localparam logic [2:0] BEAT_DW3  = 3'd3;
  localparam logic [2:0] BEAT_DW4  = 3'd4;

  function automatic logic [DW_W-1:0] hdr_word0(input logic wide);
    logic [2:0] fmt;
    fmt = wide ? FMT_4DW_WITH_DATA : FMT_3DW_WITH_DATA;
    return {fmt, TYPE_MEM, 14'd0, LEN_ONE_DW};
  endfunction

  function automatic logic [DW_W-1:0] hdr_word1();
    return {16'd0, 8'd0, BE_LAST_NONE, BE_FIRST_ALL};
  endfunction

endpackage

// File: rtl/msi_vec_arb.sv
module msi_vec_arb #(
  parameter  int CAP_LOG2 = 5,
  localparam int NV       = 1 << CAP_LOG2,
  localparam int IW       = (CAP_LOG2 > 0) ? CAP_LOG2 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mme,
  input  logic [NV-1:0] req,
  input  logic          take,
  output logic          any_pend,
  output logic [IW-1:0] grant_idx,
  output logic [2:0]    n_bits
);

  logic [NV-1:0] vmask;
  logic [NV-1:0] clr;
  logic [NV-1:0] pend_d;
  logic [NV-1:0] pend_q;

  // effective vector-number width: lesser of capability and enable code
  always_comb begin
    if (mme > 3'(CAP_LOG2)) n_bits = 3'(CAP_LOG2);
    else                    n_bits = mme;
  end

  generate
    for (genvar gi = 0; gi < NV; gi++) begin : g_vmask
      assign vmask[gi] = (32'(gi) < (32'd1 << n_bits));
    end
  endgenerate

  // lowest pending index wins
  always_comb begin
    grant_idx = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (pend_q[i]) grant_idx = IW'(i);
    end
  end

  always_comb begin
    clr = '0;
    if (take) clr[grant_idx] = 1'b1;
  end

  // a set in the same cycle as the clear wins
  always_comb begin
    if (!en) pend_d = '0;
    else     pend_d = ((pend_q & ~clr) | req) & vmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign any_pend = |pend_q;

  // R6
  off_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pend_q == '0));

  // R4
  pend_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mme) |-> ((pend_q & ~vmask) == '0));

  // R5
  take_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_q[grant_idx]);

endmodule

// File: rtl/msi_tlp_fmt.sv
module msi_tlp_fmt
  import msi_pkg::*;
#(
  parameter  int CAP_LOG2 = 5,
  parameter  int DATA_W   = 16,
  localparam int IW       = (CAP_LOG2 > 0) ? CAP_LOG2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IW-1:0]     vec,
  input  logic [2:0]        n_bits,
  input  logic [DW_W-1:0]   addr_lo,
  input  logic [DW_W-1:0]   addr_hi,
  input  logic [DATA_W-1:0] msg_data,
  input  logic [2:0]        beat,
  output logic [DW_W-1:0]   dw,
  output logic              wide,
  output logic [IW-1:0]     vec_out
);

  logic [DATA_W-1:0] vec_mask;
  logic [DATA_W-1:0] merged;

  logic [DW_W-1:0]   lo_d, lo_q;
  logic [DW_W-1:0]   hi_d, hi_q;
  logic [DATA_W-1:0] pay_d, pay_q;
  logic              wide_d, wide_q;
  logic [IW-1:0]     vec_d, vec_q;

  always_comb begin
    vec_mask = (DATA_W'(1) << n_bits) - DATA_W'(1);
    merged   = (msg_data & ~vec_mask) | (DATA_W'(vec) & vec_mask);
  end

  // snapshot on load so a message never mixes two configurations
  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    pay_d  = pay_q;
    wide_d = wide_q;
    vec_d  = vec_q;
    if (load) begin
      lo_d   = {addr_lo[DW_W-1:2], 2'b00};
      hi_d   = addr_hi;
      pay_d  = merged;
      wide_d = (addr_hi != '0);
      vec_d  = vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      pay_q  <= '0;
      wide_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      pay_q  <= pay_d;
      wide_q <= wide_d;
      vec_q  <= vec_d;
    end
  end

  always_comb begin
    case (beat)
      BEAT_DW0: dw = hdr_word0(wide_q);
      BEAT_DW1: dw = hdr_word1();
      BEAT_DW2: dw = wide_q ? hi_q : lo_q;
      BEAT_DW3: dw = wide_q ? lo_q : DW_W'(pay_q);
      default:  dw = DW_W'(pay_q);
    endcase
  end

  assign wide    = wide_q;
  assign vec_out = vec_q;

  // R3
  vec_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (vec_q == $past(vec)) && ((pay_q ^ $past(msg_data)) & ~$past(vec_mask)) == '0);

endmodule

// File: rtl/msi_beat_ctrl.sv
module msi_beat_ctrl
  import msi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       have_work,
  input  logic       wide,
  input  logic       m_ready,
  output logic       take,
  output logic [2:0] beat,
  output logic       m_valid,
  output logic       m_last,
  output logic       sent
);

  beat_st_e   st_d, st_q;
  logic [2:0] beat_d, beat_q;
  logic       sent_d, sent_q;
  logic [2:0] last_idx;
  logic       fire;

  assign last_idx = wide ? BEAT_DW4 : BEAT_DW3;
  assign m_valid  = (st_q == ST_SEND);
  assign m_last   = m_valid && (beat_q == last_idx);
  assign fire     = m_valid && m_ready;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    take   = 1'b0;
    sent_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (have_work) begin
          take   = 1'b1;
          st_d   = ST_SEND;
          beat_d = BEAT_DW0;
        end
      end
      default: begin
        if (fire) begin
          if (m_last) begin
            st_d   = ST_IDLE;
            sent_d = 1'b1;
          end else begin
            beat_d = beat_q + 3'd1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      sent_q <= sent_d;
    end
  end

  assign beat = beat_q;
  assign sent = sent_q;

  // R8
  sent_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent |-> $past(m_valid && m_ready && m_last));

  // R8
  sent_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent |=> !sent);

  // R7
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (beat_q <= BEAT_DW4));

  // R10
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> m_valid && (beat_q == BEAT_DW0));

endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
#(
  parameter  int CAP_LOG2 = 5,
  parameter  int DATA_W   = 16,
  localparam int NV       = 1 << CAP_LOG2,
  localparam int IW       = (CAP_LOG2 > 0) ? CAP_LOG2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_en,
  input  logic [2:0]        msi_mme,
  input  logic [31:0]       msi_addr_lo,
  input  logic [31:0]       msi_addr_hi,
  input  logic [DATA_W-1:0] msi_data,
  input  logic [NV-1:0]     irq_req,
  output logic              tlp_valid,
  input  logic              tlp_ready,
  output logic [31:0]       tlp_data,
  output logic              tlp_last,
  output logic              msi_sent,
  output logic [IW-1:0]     msi_sent_vec
);

  logic          any_pend;
  logic [IW-1:0] grant_idx;
  logic [2:0]    n_bits;
  logic          take;
  logic [2:0]    beat;
  logic          wide;
  logic          have_work;

  assign have_work = msi_en && any_pend;

  msi_vec_arb #(.CAP_LOG2(CAP_LOG2)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (msi_en),
    .mme       (msi_mme),
    .req       (irq_req),
    .take      (take),
    .any_pend  (any_pend),
    .grant_idx (grant_idx),
    .n_bits    (n_bits)
  );

  msi_tlp_fmt #(.CAP_LOG2(CAP_LOG2), .DATA_W(DATA_W)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .vec      (grant_idx),
    .n_bits   (n_bits),
    .addr_lo  (msi_addr_lo),
    .addr_hi  (msi_addr_hi),
    .msg_data (msi_data),
    .beat     (beat),
    .dw       (tlp_data),
    .wide     (wide),
    .vec_out  (msi_sent_vec)
  );

  msi_beat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_work (have_work),
    .wide      (wide),
    .m_ready   (tlp_ready),
    .take      (take),
    .beat      (beat),
    .m_valid   (tlp_valid),
    .m_last    (tlp_last),
    .sent      (msi_sent)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlp_valid && !tlp_ready |=> tlp_valid && $stable(tlp_data) && $stable(tlp_last));

  // R1
  first_beat_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlp_valid) |-> (tlp_data[28:24] == TYPE_MEM) && (tlp_data[9:0] == LEN_ONE_DW));

endmodule

// File: tb/msi_msg_gen_test.sv
`timescale 1ns/1ps
module msi_msg_gen_test;

  logic        clk;
  logic        rst_n;
  logic        msi_en;
  logic [2:0]  msi_mme;
  logic [31:0] msi_addr_lo;
  logic [31:0] msi_addr_hi;
  logic [15:0] msi_data;
  logic [31:0] irq_req;
  logic        tlp_valid;
  logic        tlp_ready;
  logic [31:0] tlp_data;
  logic        tlp_last;
  logic        msi_sent;
  logic [4:0]  msi_sent_vec;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] dq[$];
  bit          lq[$];
  int          sq[$];

  msi_msg_gen uut (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .msi_mme(msi_mme),
    .msi_addr_lo(msi_addr_lo), .msi_addr_hi(msi_addr_hi), .msi_data(msi_data),
    .irq_req(irq_req), .tlp_valid(tlp_valid), .tlp_ready(tlp_ready),
    .tlp_data(tlp_data), .tlp_last(tlp_last), .msi_sent(msi_sent),
    .msi_sent_vec(msi_sent_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // capture accepted beats and acknowledgements away from the rising edge
  always @(negedge clk) begin
    if (rst_n && tlp_valid && tlp_ready) begin
      dq.push_back(tlp_data);
      lq.push_back(tlp_last);
    end
    if (rst_n && msi_sent) sq.push_back(int'(msi_sent_vec));
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dw(input int v, input int b);
    bit          wide;
    int          n;
    logic [15:0] m;
    logic [15:0] pay;
    wide = (msi_addr_hi != 0);
    n    = (msi_mme > 3'd5) ? 5 : int'(msi_mme);
    m    = 16'((1 << n) - 1);
    pay  = (msi_data & ~m) | (16'(v) & m);
    case (b)
      0: return wide ? 32'h6000_0001 : 32'h4000_0001;
      1: return 32'h0000_000F;
      2: return wide ? msi_addr_hi : {msi_addr_lo[31:2], 2'b00};
      3: return wide ? {msi_addr_lo[31:2], 2'b00} : {16'd0, pay};
      default: return {16'd0, pay};
    endcase
  endfunction

  task automatic check_msg(input int v, input string rq);
    int nb;
    nb = (msi_addr_hi != 0) ? 5 : 4;
    for (int b = 0; b < nb; b++) begin
      if (dq.size() == 0) begin
        check(0, rq, 32'hDEAD_BEEF, exp_dw(v, b));
      end else begin
        logic [31:0] d;
        bit          l;
        d = dq.pop_front();
        l = lq.pop_front();
        check(d == exp_dw(v, b), rq, d, exp_dw(v, b));
        check(l == (b == nb - 1), "R7 last flag", 32'(l), 32'(b == nb - 1));
      end
    end
    if (sq.size() == 0) check(0, "R8 sent pulse", 32'hFFFF_FFFF, 32'(v));
    else begin
      int s;
      s = sq.pop_front();
      check(s == v, "R8 sent vector", 32'(s), 32'(v));
    end
  endtask

  task automatic check_empty(input string rq);
    check(dq.size() == 0, rq, 32'(dq.size()), 32'd0);
    check(sq.size() == 0, rq, 32'(sq.size()), 32'd0);
    dq.delete();
    lq.delete();
    sq.delete();
  endtask

  task automatic pulse(input logic [31:0] bits);
    irq_req = bits;
    cyc(1);
    irq_req = '0;
  endtask

  task automatic t_reset;
    check(tlp_valid == 1'b0, "R10 reset valid", 32'(tlp_valid), 32'd0);
    check(msi_sent == 1'b0, "R10 reset sent", 32'(msi_sent), 32'd0);
  endtask

  task automatic t_single32;
    msi_en = 1; msi_mme = 3'd0; msi_addr_lo = 32'hFEE0_1003; msi_addr_hi = 0;
    msi_data = 16'h4B27;
    pulse(32'h1);
    cyc(12);
    check_msg(0, "R1 32-bit message");
    check_empty("R1 no extra");
  endtask

  task automatic t_wide64;
    msi_mme = 3'd5; msi_addr_hi = 32'h0000_0001; msi_addr_lo = 32'hFEE0_0040;
    msi_data = 16'hA5C0;
    pulse(32'h1 << 19);
    cyc(12);
    check_msg(19, "R2 64-bit message");
    check_empty("R2 no extra");
    msi_addr_hi = 0;
  endtask

  task automatic t_merge;
    msi_mme = 3'd7; msi_data = 16'h1234;
    pulse(32'h1 << 31);
    cyc(12);
    check_msg(31, "R3 clamped merge");
    msi_mme = 3'd2; msi_data = 16'hFFFF;
    pulse(32'h1 << 1);
    cyc(12);
    check_msg(1, "R3 two-bit merge");
    check_empty("R3 no extra");
  endtask

  task automatic t_mask;
    msi_mme = 3'd2; msi_data = 16'h0100;
    pulse((32'h1 << 9) | (32'h1 << 2));
    cyc(20);
    check_msg(2, "R4 in-range vector");
    check_empty("R4 bit 9 ignored");
    msi_mme = 3'd0;
    pulse(32'h1 << 5);
    cyc(15);
    check_empty("R4 single vector bit 5 ignored");
    pulse(32'h1);
    cyc(12);
    check_msg(0, "R4 single vector bit 0");
    check_empty("R4 no extra");
  endtask

  task automatic t_order;
    msi_mme = 3'd3; msi_data = 16'h0F00;
    pulse((32'h1 << 6) | (32'h1 << 1) | (32'h1 << 3));
    cyc(30);
    check_msg(1, "R5 first lowest");
    check_msg(3, "R5 second");
    check_msg(6, "R5 third");
    check_empty("R5 no extra");
  endtask

  task automatic t_disabled;
    msi_en = 0; msi_mme = 3'd3;
    pulse(32'h1);
    cyc(10);
    msi_en = 1;
    cyc(10);
    check_empty("R6 dropped while disabled");
    tlp_ready = 0;
    pulse((32'h1 << 1) | (32'h1 << 2));
    cyc(3);
    msi_en = 0;
    cyc(2);
    tlp_ready = 1;
    cyc(10);
    msi_en = 1;
    cyc(10);
    check_msg(1, "R6 in-flight completes");
    check_empty("R6 pending discarded");
  endtask

  task automatic t_backpressure;
    msi_mme = 3'd3; msi_addr_hi = 32'h0000_00AB; msi_addr_lo = 32'hFEE0_0010;
    msi_data = 16'h7770;
    tlp_ready = 0;
    pulse(32'h1 << 4);
    cyc(3);
    check(tlp_valid == 1'b1, "R7 valid during stall", 32'(tlp_valid), 32'd1);
    check(tlp_data == 32'h6000_0001, "R7 data during stall", tlp_data, 32'h6000_0001);
    cyc(3);
    check(tlp_data == 32'h6000_0001, "R7 data held", tlp_data, 32'h6000_0001);
    check(dq.size() == 0, "R7 no beat without ready", 32'(dq.size()), 32'd0);
    for (int k = 0; k < 30; k++) begin
      tlp_ready = (k % 3 == 0);
      cyc(1);
    end
    tlp_ready = 1;
    cyc(5);
    check_msg(4, "R7 message under backpressure");
    check_empty("R7 no extra");
    msi_addr_hi = 0;
  endtask

  task automatic t_collision;
    msi_mme = 3'd3; msi_data = 16'h2200;
    irq_req = 32'h1 << 5;
    cyc(1);
    check(tlp_valid == 1'b0, "R10 not yet valid", 32'(tlp_valid), 32'd0);
    cyc(1);
    check(tlp_valid == 1'b1, "R10 valid after grant", 32'(tlp_valid), 32'd1);
    irq_req = '0;
    cyc(20);
    check_msg(5, "R9 first message");
    check_msg(5, "R9 kept request");
    check_empty("R9 no extra");
  endtask

  initial begin
    rst_n = 0; msi_en = 0; msi_mme = 0; msi_addr_lo = 0; msi_addr_hi = 0;
    msi_data = 0; irq_req = 0; tlp_ready = 1;
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_reset();
    t_single32();
    t_wide64();
    t_merge();
    t_mask();
    t_order();
    t_disabled();
    t_backpressure();
    t_collision();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule